// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block generates the per-bit drive enables for a quasi-bidirectional I/O port, one with no direction register. Each bit has an output latch that software sets through byte-pair writes. When a complete write is committed, the latch loads the new word. A bit that holds 0 enables a strong pull-down. A bit that holds 1 keeps only a weak pull-up, so an external source can pull the pad low, and the bit then works as an input.

Each time a 1 is committed to a bit, a strong pull-up fires for that bit. This gives a fast rising edge on a heavily loaded pad. The boost ends at the next falling edge of the serial clock, which the block watches on an input that is already synchronous to its clock. Reads take the pad value straight through, with no register in the path. Reset drives every latch bit high, so after power-up all pins are usable as inputs.

Top module: `qbd_port_ctrl`

## Requirements
- R1: After reset, every bit latches 1: pull-down enable is 0, weak pull-up enable is 1 and strong pull-up enable is 0 for all bits.
- R2: A commit strobe sampled high at a clock edge loads the write word into the latch. From that edge on, the pull-down enable of each bit is the inverse of its new latched value.
- R3: The weak pull-up enable of each bit equals its latched value at all times.
- R4: Each bit committed as 1 raises its strong pull-up enable at that same edge. This applies whether the latch held 0 or 1 before the commit.
- R5: A serial-clock falling edge clears every active strong pull-up enable at the clock edge where it is seen. A falling edge is seen when the serial-clock input is sampled 0 and the previous sample was 1.
- R6: Without a commit or a serial-clock falling edge, every strong pull-up enable holds its value. A rising or steady serial clock does not end a boost.
- R7: When a commit and a serial-clock falling edge occur at the same edge, the commit wins. Bits written as 1 start a new boost.
- R8: A bit committed as 0 drops its strong pull-up enable at the commit edge, even when no serial-clock edge occurs.
- R9: Pull-down and strong pull-up are never enabled together on the same bit.
- R10: The read data output equals the pad input in the same cycle, with no register in the path.
- R11: Driving the reset input low forces the reset state of R1 at once, without waiting for a clock edge. Release of reset takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| commit_i | input | 1 | Pulse that commits a completed byte-pair write |
| wr_data_i | input | WIDTH | Word loaded into the latch on commit |
| scl_i | input | 1 | Serial-clock level, synchronous to clk; idle high |
| pad_i | input | WIDTH | Pad levels seen on the pins |
| rd_data_o | output | WIDTH | Pad levels returned for reads |
| pd_en_o | output | WIDTH | Strong pull-down enable per bit |
| wpu_en_o | output | WIDTH | Weak pull-up enable per bit |
| spu_en_o | output | WIDTH | Momentary strong pull-up enable per bit |

## Verification
The hardest case to reach is a commit that arrives in the same cycle as a serial-clock falling edge, since the start and the end of a boost then compete for the same bit. The stimulus table first leaves the serial clock high for one vector and then drives it low together with a commit, so both events fall on one edge. The table also commits zeros while the serial clock stays low. This shows that a boost can end at a commit even when there is no clock edge. A separate directed step asserts reset between clock edges to confirm that the reset state appears without waiting for a clock.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef struct packed {
    logic pd;
    logic wpu;
    logic spu;
  } drv_t;

  localparam logic LATCH_RESET = 1'b1;
  localparam logic SCL_IDLE    = 1'b1;
endpackage

// File: rtl/qbd_rst_sync.sv
module qbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qbd_edge_det.sv
module qbd_edge_det
  import qbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic scl_fall
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= SCL_IDLE;
    else        scl_q <= scl_i;
  end

  assign scl_fall = scl_q & ~scl_i;
endmodule

// File: rtl/qbd_bit_ctrl.sv
module qbd_bit_ctrl
  import qbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic wr_bit,
  input  logic scl_fall,
  output drv_t drv
);
  logic latch_q, latch_d, latch_en;
  logic boost_q, boost_d, boost_en;

  always_comb begin
    latch_en = commit;
    latch_d  = wr_bit;
    boost_en = commit | scl_fall;
    if (commit) boost_d = wr_bit;
    else        boost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= LATCH_RESET;
      boost_q <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      if (boost_en) boost_q <= boost_d;
    end
  end

  always_comb begin
    drv.pd  = ~latch_q;
    drv.wpu = latch_q;
    drv.spu = boost_q;
  end

  // R2
  a_r2_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (latch_q == $past(wr_bit)));
  // R4
  a_r4_boost_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_bit) |=> drv.spu);
  // R5
  a_r5_fall_ends_boost: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !commit) |=> !drv.spu);
  // R6
  a_r6_boost_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !commit) |=> $stable(drv.spu));
  // R8
  a_r8_low_write_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_bit) |=> !drv.spu);
endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl
  import qbd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             scl_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] pd_en_o,
  output logic [WIDTH-1:0] wpu_en_o,
  output logic [WIDTH-1:0] spu_en_o
);
  logic rst_int_n;
  logic scl_fall;
  logic rst_gate_n;

  qbd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign rst_gate_n = rst_int_n & rst_n;

  qbd_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_gate_n),
    .scl_i    (scl_i),
    .scl_fall (scl_fall)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    drv_t drv;
    qbd_bit_ctrl u_bit (
      .clk      (clk),
      .rst_n    (rst_gate_n),
      .commit   (commit_i),
      .wr_bit   (wr_data_i[b]),
      .scl_fall (scl_fall),
      .drv      (drv)
    );
    assign pd_en_o[b]  = drv.pd;
    assign wpu_en_o[b] = drv.wpu;
    assign spu_en_o[b] = drv.spu;
  end

  assign rd_data_o = pad_i;

  // R9
  a_r9_no_fight: assert property (@(posedge clk) disable iff (!rst_gate_n)
    (pd_en_o & spu_en_o) == '0);
  // R3
  a_r3_weak_is_latch: assert property (@(posedge clk) disable iff (!rst_gate_n)
    wpu_en_o == ~pd_en_o);
endmodule

// File: tb/tb_qbd_port_ctrl.sv
`timescale 1ns/1ps
module tb_qbd_port_ctrl;
  localparam int W = 16;
  localparam int NV = 9;

  logic clk, rst_n, commit_i, scl_i;
  logic [W-1:0] wr_data_i, pad_i, rd_data_o, pd_en_o, wpu_en_o, spu_en_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  qbd_port_ctrl #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .wr_data_i(wr_data_i),
    .scl_i(scl_i), .pad_i(pad_i), .rd_data_o(rd_data_o), .pd_en_o(pd_en_o),
    .wpu_en_o(wpu_en_o), .spu_en_o(spu_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {commit, scl, data, expected pull-down, expected strong pull-up}
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h00FF, 16'hFF00, 16'h00FF},  // R2 R4 write
    {1'b0, 1'b1, 16'h0000, 16'hFF00, 16'h00FF},  // R6 hold, scl high
    {1'b0, 1'b0, 16'h0000, 16'hFF00, 16'h0000},  // R5 falling edge
    {1'b0, 1'b0, 16'h0000, 16'hFF00, 16'h0000},  // R6 steady low
    {1'b1, 1'b1, 16'hA5A5, 16'h5A5A, 16'hA5A5},  // R4 rising scl + write
    {1'b1, 1'b0, 16'h0F0F, 16'hF0F0, 16'h0F0F},  // R7 commit with fall
    {1'b1, 1'b0, 16'h0000, 16'hFFFF, 16'h0000},  // R8 zeros end boost
    {1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF},  // R4 rewrite highs
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000}   // R5 fall clears all
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; commit_i = 1'b0; scl_i = 1'b1; wr_data_i = '0; pad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 pd", pd_en_o, 16'h0000);
    check("R1 wpu", wpu_en_o, 16'hFFFF);
    check("R1 spu", spu_en_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      commit_i  = VEC[i][49];
      scl_i     = VEC[i][48];
      wr_data_i = VEC[i][47:32];
      @(posedge clk);
      #2;
      check($sformatf("R2 pd v%0d", i), pd_en_o, VEC[i][31:16]);
      check($sformatf("R3 wpu v%0d", i), wpu_en_o, ~VEC[i][31:16]);
      check($sformatf("R4-5-6-7-8 spu v%0d", i), spu_en_o, VEC[i][15:0]);
      check($sformatf("R9 overlap v%0d", i), pd_en_o & spu_en_o, 16'h0000);
    end

    // R10 pad passthrough
    @(negedge clk);
    commit_i = 1'b0;
    pad_i = 16'h3C96;
    #1 check("R10 rd", rd_data_o, 16'h3C96);
    pad_i = 16'hC369;
    #1 check("R10 rd", rd_data_o, 16'hC369);

    // Set a mixed state, then assert reset between edges (R11)
    @(negedge clk);
    commit_i = 1'b1; scl_i = 1'b1; wr_data_i = 16'h1234;
    @(negedge clk);
    commit_i = 1'b0;
    check("R11 pre pd", pd_en_o, 16'hEDCB);
    #3 rst_n = 1'b0;
    #1;
    check("R11 pd", pd_en_o, 16'h0000);
    check("R11 wpu", wpu_en_o, 16'hFFFF);
    check("R11 spu", spu_en_o, 16'h0000);
    // release: commit ignored until two edges pass
    @(negedge clk);
    rst_n = 1'b1;
    commit_i = 1'b1; wr_data_i = 16'h0000;
    @(posedge clk); #2;
    check("R11 held", pd_en_o, 16'h0000);
    @(posedge clk); #2;
    check("R11 held2", pd_en_o, 16'h0000);
    @(posedge clk); #2;
    check("R11 released R2", pd_en_o, 16'hFFFF);
    @(negedge clk);
    commit_i = 1'b0;
    finish_run();
  end
endmodule